// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address used by a synchronous memory during a four-beat burst. When a burst starts, it captures the address presented by the requester. On later cycles it either moves to the next beat or keeps the current beat. Only the two least significant address bits change during a burst. The bits above them keep the value that was captured.

The beat order is set by a static mode input. In interleaved order, the low pair of bits is the captured pair XORed with the beat number. In linear order, the low pair counts upward from the captured pair and wraps within the aligned group of four. The beat counter is a four-state machine with the states BEAT_0, BEAT_1, BEAT_2 and BEAT_3. Its transitions are:
- LOAD: any state goes to BEAT_0 on a burst start.
- STEP: BEAT_n goes to BEAT_n+1 on an advance, and BEAT_3 goes to BEAT_0.
- HOLD: the state is unchanged when there is neither a start nor an advance.
- CLEAR: any state goes to BEAT_0 on reset.

Top module: `burst_addr_gen`

## Requirements
- R1: Address bits [AW-1:2] of the output equal bits [AW-1:2] of the address captured at the most recent burst start, or zero since reset. No advance or hold changes them.
- R2: When `mode_ilv_i` is 1 (interleaved), the low two output bits at beat k (k = 0..3) are the captured low bits XOR k.
- R3: When `mode_ilv_i` is 0 (linear), the low two output bits at beat k are (captured low bits + k) mod 4. For example, a start of 2'b10 gives 10, 11, 00, 01.
- R4: `mode_ilv_i` acts only on the mapping from beat to address. The beat state itself is the same in both modes.
- R5: A cycle with `burst_start_i` = 1 captures `addr_i` at the rising edge and enters BEAT_0. This holds even when `step_n_i` is 0 in the same cycle.
- R6: A cycle with `burst_start_i` = 0 and `step_n_i` = 0 moves the beat forward by one at the rising edge.
- R7: A cycle with `burst_start_i` = 0 and `step_n_i` = 1 leaves the output address unchanged.
- R8: An advance from BEAT_3 returns to BEAT_0, which gives the first-beat address again. The captured base is kept.
- R9: A synchronous reset (`rst` = 1 at a rising edge) sets the captured base to zero and the beat to BEAT_0, so the output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| burst_start_i | input | 1 | Begin-burst strobe, active high |
| addr_i | input | AW | External address captured on a burst start |
| step_n_i | input | 1 | Advance request, active low |
| mode_ilv_i | input | 1 | Order select: 1 = interleaved, 0 = linear; static |
| addr_o | output | AW | Current burst word address |

## Verification
The embedded assertions check the following on every cycle:
- LOAD goes to BEAT_0.
- STEP goes forward by one, including the wrap from BEAT_3.
- HOLD keeps the beat stable.
- The upper address bits are kept, or newly captured on a start.

Only the bench's scenarios can show the rest. This covers the full interleaved and linear address sequences for different start offsets, and the priority of a start over an advance. It also covers the reset value and the first-beat address repeating after the fourth beat. These all need a reference model of the address values, which the assertions do not contain.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic [1:0] {
        BEAT_0 = 2'd0,
        BEAT_1 = 2'd1,
        BEAT_2 = 2'd2,
        BEAT_3 = 2'd3
    } beat_e;

    localparam int OFS_W = 2;
endpackage

// File: rtl/bag_beat_fsm.sv
module bag_beat_fsm
    import bag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             step_n_i,
    output logic [OFS_W-1:0] beat_o
);
    beat_e beat_q, beat_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) beat_q <= BEAT_0;
        else     beat_q <= beat_d;
    end

    // next-state: LOAD has priority over STEP, otherwise HOLD
    always_comb begin
        beat_d = beat_q;
        if (start_i) begin
            beat_d = BEAT_0;
        end else if (!step_n_i) begin
            unique case (beat_q)
                BEAT_0: beat_d = BEAT_1;
                BEAT_1: beat_d = BEAT_2;
                BEAT_2: beat_d = BEAT_3;
                BEAT_3: beat_d = BEAT_0;
                default: beat_d = BEAT_0;
            endcase
        end
    end

    // output process
    always_comb begin
        beat_o = beat_q;
    end

    // R5: a start always lands in BEAT_0
    a_r5_load_first: assert property (@(posedge clk) disable iff (rst)
        start_i |=> beat_q == BEAT_0);

    // R6: an advance moves one beat forward
    a_r6_step_one: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !step_n_i) |=> beat_q == beat_e'($past(beat_q) + 2'd1));

    // R7: hold keeps the beat
    a_r7_hold_beat: assert property (@(posedge clk) disable iff (rst)
        (!start_i && step_n_i) |=> $stable(beat_q));

    // R8: wrap after the fourth beat
    a_r8_wrap_first: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !step_n_i && beat_q == BEAT_3) |=> beat_q == BEAT_0);
endmodule

// File: rtl/bag_base_reg.sv
module bag_base_reg #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] base_o
);
    logic [AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst)          base_q <= '0;
        else if (start_i) base_q <= addr_i;
    end

    assign base_o = base_q;

    // R9: reset leaves the base at zero
    a_r9_base_clear: assert property (@(posedge clk)
        disable iff (start_i) rst |=> base_q == '0);
endmodule

// File: rtl/bag_low_map.sv
module bag_low_map
    import bag_pkg::*;
(
    input  logic             mode_ilv_i,
    input  logic [OFS_W-1:0] base_lo_i,
    input  logic [OFS_W-1:0] beat_i,
    output logic [OFS_W-1:0] lo_o
);
    logic [OFS_W-1:0] ilv_lo;
    logic [OFS_W-1:0] lin_lo;

    always_comb begin
        ilv_lo = base_lo_i ^ beat_i;   // interleaved order
        lin_lo = base_lo_i + beat_i;   // linear order, wraps mod 4
        lo_o   = mode_ilv_i ? ilv_lo : lin_lo;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          burst_start_i,
    input  logic [AW-1:0] addr_i,
    input  logic          step_n_i,
    input  logic          mode_ilv_i,
    output logic [AW-1:0] addr_o
);
    localparam int HI_W = AW - OFS_W;

    logic [AW-1:0]    base;
    logic [OFS_W-1:0] beat;
    logic [OFS_W-1:0] lo;

    bag_beat_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_i  (burst_start_i),
        .step_n_i (step_n_i),
        .beat_o   (beat)
    );

    bag_base_reg #(.AW(AW)) u_base (
        .clk     (clk),
        .rst     (rst),
        .start_i (burst_start_i),
        .addr_i  (addr_i),
        .base_o  (base)
    );

    bag_low_map u_map (
        .mode_ilv_i (mode_ilv_i),
        .base_lo_i  (base[OFS_W-1:0]),
        .beat_i     (beat),
        .lo_o       (lo)
    );

    assign addr_o = {base[AW-1:OFS_W], lo};

    // R1: upper bits kept outside a start
    a_r1_upper_hold: assert property (@(posedge clk) disable iff (rst)
        !burst_start_i |=> $stable(addr_o[AW-1:OFS_W]));

    // R1: upper bits follow the captured address after a start
    a_r1_upper_load: assert property (@(posedge clk) disable iff (rst)
        burst_start_i |=> addr_o[AW-1:OFS_W] == $past(addr_i[AW-1:OFS_W]));

    initial begin
        a_r1_width_ok: assert (HI_W >= 1);
    end
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          burst_start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          step_n_i = 1'b1;
    logic          mode_ilv_i = 1'b1;
    logic [AW-1:0] addr_o;

    burst_addr_gen #(.AW(AW)) dut (
        .clk           (clk),
        .rst           (rst),
        .burst_start_i (burst_start_i),
        .addr_i        (addr_i),
        .step_n_i      (step_n_i),
        .mode_ilv_i    (mode_ilv_i),
        .addr_o        (addr_o)
    );

    always #10 clk = ~clk;

    // scoreboard queues
    logic [AW-1:0] exp_q[$];
    string         tag_q[$];
    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = 2'd0;

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] lo;
        lo = mode_ilv_i ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic cyc(input bit r, input bit st, input logic [AW-1:0] a,
                       input bit stn, input string tag);
        @(negedge clk);
        #2;
        rst = r; burst_start_i = st; addr_i = a; step_n_i = stn;
        @(posedge clk);
        if (r) begin
            m_base = '0; m_beat = 2'd0;
        end else if (st) begin
            m_base = a; m_beat = 2'd0;
        end else if (!stn) begin
            m_beat = m_beat + 2'd1;
        end
        exp_q.push_back(model_addr());
        tag_q.push_back(tag);
    endtask

    task automatic set_mode(input bit m);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        #2;
        mode_ilv_i = m;
        burst_start_i = 1'b0; step_n_i = 1'b1;
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [AW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (addr_o !== e) begin
                n_fail++;
                $display("FAIL %s: addr_o=%h expected=%h", t, addr_o, e);
            end
        end
    end

    initial begin
        // R9: reset state
        cyc(1, 0, '0, 1, "R9 reset");
        cyc(1, 0, '0, 1, "R9 reset");
        // interleaved, base low 01: 01,00,11,10 (R2, R4)
        cyc(0, 1, 20'hABCD5, 1, "R5 R1 load");
        cyc(0, 0, 20'h00000, 0, "R2 R6 beat1");
        cyc(0, 0, 20'h11111, 0, "R2 R6 beat2");
        cyc(0, 0, 20'h22222, 0, "R2 R6 beat3");
        cyc(0, 0, 20'h33333, 0, "R8 wrap first");
        // suspend
        cyc(0, 0, 20'hFFFFF, 1, "R7 hold");
        cyc(0, 0, 20'h0F0F0, 1, "R7 hold");
        cyc(0, 0, 20'h00000, 0, "R6 after hold");
        // start with simultaneous advance: start wins
        cyc(0, 1, 20'h12346, 0, "R5 priority");
        cyc(0, 0, 20'h00000, 0, "R2 R1 beat1");
        cyc(0, 0, 20'h00000, 0, "R2 beat2");
        cyc(0, 0, 20'h00000, 0, "R2 beat3");
        // linear mode (R3, R4)
        set_mode(0);
        cyc(0, 1, 20'h5A5A6, 1, "R3 load 10");
        cyc(0, 0, 20'h00000, 0, "R3 beat1 11");
        cyc(0, 0, 20'h00000, 0, "R3 beat2 00");
        cyc(0, 0, 20'h00000, 0, "R3 beat3 01");
        cyc(0, 0, 20'h00000, 0, "R8 R3 wrap");
        cyc(0, 1, 20'hFFFFF, 1, "R3 load 11");
        cyc(0, 0, 20'h00000, 0, "R3 R1 beat1");
        cyc(0, 0, 20'h00000, 1, "R7 linear hold");
        cyc(0, 0, 20'h00000, 0, "R3 beat2");
        // reset mid-burst
        cyc(1, 0, 20'h00000, 0, "R9 mid reset");
        cyc(0, 0, 20'h00000, 0, "R6 R9 step from zero");
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule